// File: doc/BRIEF.md
# Baugh-Wooley Signed Array Multiplier

This block multiplies two two's-complement operands and returns their full-precision signed product in a single combinational pass. The operand widths are set separately by parameters. The narrower operand is sign-extended to the common width `N`, which is the larger of the two widths. The product is `2N` bits wide.

The structure is a regular array. An `N`×`N` field of single-gate partial-product terms feeds `N-1` rows of ripple adders. Each row starts with a half adder and continues with full adders. Carries run from the low multiplicand position to the high one, and each row's last carry enters the top position of the row below it.

Signs are resolved inside the array, so the partial products never need sign extension:

- every term that pairs exactly one sign bit with a non-sign bit is inverted;
- a constant one enters the first adder row at its top position;
- the final carry of the last row is inverted to form the product's sign bit.

A one-bit configuration collapses to a single AND gate with a zero upper bit.

Top module: `bw_mult`

## Requirements
- R1: For every input pair, `prod_o` equals the signed product of `mcand_i` and `mplier_i`, written as a `2N`-bit two's-complement value, where `N` is the larger operand width.
- R2: An operand narrower than `N` is treated as signed and sign-extended. With `WA=8`, `WB=6`, `mcand_i=1` and `mplier_i=6'h20`, the product is `16'hFFE0` (-32).
- R3: Product bit 0 always equals `mcand_i[0] AND mplier_i[0]`.
- R4: When `N` is 1, `prod_o[1]` is always 0 and `prod_o[0]` is the AND of the two input bits.
- R5: The most negative operand multiplied by itself gives `2^(2N-2)`. For example, with `N=4`, -8 × -8 gives `8'h40`.
- R6: A zero on either operand gives an all-zero product.
- R7: When both operands are nonzero, `prod_o[2N-1]` is 1 exactly when the operand sign bits differ.
- R8: The block has no storage, so `prod_o` follows the current inputs within the same cycle they are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_i | input | WA | Signed multiplicand |
| mplier_i | input | WB | Signed multiplier |
| prod_o | output | 2*max(WA,WB) | Signed product |

## Verification
The block holds no state, so any wrong internal value (an inverted term placed wrongly, a missing constant one, or a broken carry link between rows) shows on `prod_o` in the same cycle the inputs are applied. Only some input patterns expose a given fault. A misplaced inversion or a lost constant matters only when the sign bits are involved. A broken row link shows only when that row actually produces a carry. For this reason, every operand pair is applied for square widths 1 through 5 and for the unequal 8-by-6 configuration. The most-negative, zero and opposite-sign cases are also checked against their own requirements.

// File: rtl/bw_mult_pkg.sv
package bw_mult_pkg;

   // Larger of two widths.
   function automatic int unsigned wmax(input int unsigned x, input int unsigned y);
      return (x > y) ? x : y;
   endfunction

   // A term is inverted when exactly one of its indices is the sign position.
   function automatic bit term_inverted(input int unsigned i, input int unsigned j,
                                        input int unsigned n);
      return (i == n - 1) ^ (j == n - 1);
   endfunction

endpackage

// File: rtl/bw_ha.sv
module bw_ha (
   input  logic x_i,
   input  logic y_i,
   output logic s_o,
   output logic c_o
);
   assign s_o = x_i ^ y_i;
   assign c_o = x_i & y_i;
endmodule

// File: rtl/bw_fa.sv
module bw_fa (
   input  logic x_i,
   input  logic y_i,
   input  logic z_i,
   output logic s_o,
   output logic c_o
);
   logic xy;
   assign xy  = x_i ^ y_i;
   assign s_o = xy ^ z_i;
   assign c_o = (x_i & y_i) | (xy & z_i);
endmodule

// File: rtl/bw_pp_matrix.sv
module bw_pp_matrix
   import bw_mult_pkg::*;
#(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0]   a_i,
   input  logic [N-1:0]   b_i,
   output logic [N*N-1:0] pp_o      // term (i,j) at index j*N+i
);
   for (genvar j = 0; j < N; j++) begin : g_row
      for (genvar i = 0; i < N; i++) begin : g_col
         if (term_inverted(i, j, N)) begin : g_nand
            assign pp_o[j*N+i] = ~(a_i[i] & b_i[j]);
         end else begin : g_and
            assign pp_o[j*N+i] = a_i[i] & b_i[j];
         end
      end
   end
endmodule

// File: rtl/bw_adder_row.sv
module bw_adder_row #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] pp_i,       // this row's partial products
   input  logic [N-1:0] upper_i,    // terms handed down from the row above
   output logic [N-1:0] sum_o,
   output logic         cout_o
);
   logic [N:1] chain;

   for (genvar i = 0; i < N; i++) begin : g_cell
      if (i == 0) begin : g_half
         bw_ha u_ha (
            .x_i (pp_i[0]),
            .y_i (upper_i[0]),
            .s_o (sum_o[0]),
            .c_o (chain[1])
         );
      end else begin : g_full
         bw_fa u_fa (
            .x_i (pp_i[i]),
            .y_i (upper_i[i]),
            .z_i (chain[i]),
            .s_o (sum_o[i]),
            .c_o (chain[i+1])
         );
      end
   end

   assign cout_o = chain[N];
endmodule

// File: rtl/bw_mult.sv
module bw_mult
   import bw_mult_pkg::*;
#(
   parameter int unsigned WA = 8,
   parameter int unsigned WB = 6
) (
   input  logic [WA-1:0]                      mcand_i,
   input  logic [WB-1:0]                      mplier_i,
   output logic [2*((WA > WB) ? WA : WB)-1:0] prod_o
);
   localparam int unsigned N = wmax(WA, WB);
   localparam int unsigned P = 2 * N;

   if (WA < 1 || WB < 1) begin : g_bad_width
      $error("bw_mult: operand widths must be at least 1");
   end

   // Sign extension to the common width
   logic [N-1:0] a_ext;
   logic [N-1:0] b_ext;

   if (WA == N) begin : g_a_full
      assign a_ext = mcand_i;
   end else begin : g_a_ext
      assign a_ext = {{(N-WA){mcand_i[WA-1]}}, mcand_i};
   end

   if (WB == N) begin : g_b_full
      assign b_ext = mplier_i;
   end else begin : g_b_ext
      assign b_ext = {{(N-WB){mplier_i[WB-1]}}, mplier_i};
   end

   logic [N*N-1:0] pp;

   bw_pp_matrix #(.N(N)) u_pp (
      .a_i  (a_ext),
      .b_i  (b_ext),
      .pp_o (pp)
   );

   if (N == 1) begin : g_single
      assign prod_o = {1'b0, pp[0]};
   end else begin : g_array
      logic [N-1:0] row_sum   [1:N-1];
      logic         row_cy    [1:N-1];
      logic [N-1:0] row_upper [1:N-1];

      for (genvar j = 1; j < N; j++) begin : g_row
         if (j == 1) begin : g_first
            // constant one at the top position replaces a missing term
            assign row_upper[j] = {1'b1, pp[N-1:1]};
         end else begin : g_next
            assign row_upper[j] = {row_cy[j-1], row_sum[j-1][N-1:1]};
         end

         bw_adder_row #(.N(N)) u_row (
            .pp_i    (pp[j*N +: N]),
            .upper_i (row_upper[j]),
            .sum_o   (row_sum[j]),
            .cout_o  (row_cy[j])
         );

         if (j < N - 1) begin : g_mid_bit
            assign prod_o[j] = row_sum[j][0];
         end
      end

      assign prod_o[0]           = pp[0];
      assign prod_o[P-2:N-1]     = row_sum[N-1];
      assign prod_o[P-1]         = ~row_cy[N-1];
   end
endmodule

// File: rtl/bw_mult_chk.sv
module bw_mult_chk #(
   parameter int unsigned WA = 8,
   parameter int unsigned WB = 6
) (
   input logic [WA-1:0]                      mcand_i,
   input logic [WB-1:0]                      mplier_i,
   input logic [2*((WA > WB) ? WA : WB)-1:0] prod_o
);
   localparam int unsigned N = (WA > WB) ? WA : WB;
   localparam int unsigned P = 2 * N;

   logic signed [P-1:0] ax;
   logic signed [P-1:0] bx;
   logic signed [P-1:0] ref_p;

   always_comb begin
      ax    = $signed(mcand_i);
      bx    = $signed(mplier_i);
      ref_p = ax * bx;
   end

   always_comb begin
      if (!$isunknown({mcand_i, mplier_i, prod_o})) begin
         p_match_r1: assert (prod_o == ref_p)
            else $error("R1 product mismatch");
         p_ext_r2: assert (!(ax == 1) || prod_o == bx)
            else $error("R2 multiplier not sign-extended");
         p_bit0_r3: assert (prod_o[0] == (mcand_i[0] & mplier_i[0]))
            else $error("R3 bit 0 wrong");
         p_single_r4: assert (N != 1 || prod_o[P-1] == 1'b0)
            else $error("R4 upper bit not zero");
         p_zero_r6: assert (!(ax == 0 || bx == 0) || prod_o == '0)
            else $error("R6 nonzero product from zero operand");
         p_sign_r7: assert (ax == 0 || bx == 0 ||
                            prod_o[P-1] == (ax[P-1] ^ bx[P-1]))
            else $error("R7 sign bit wrong");
      end
   end
endmodule

bind bw_mult bw_mult_chk #(.WA(WA), .WB(WB)) u_chk (
   .mcand_i  (mcand_i),
   .mplier_i (mplier_i),
   .prod_o   (prod_o)
);

// File: tb/bw_mult_test.sv
module bw_mult_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [7:0] a_in = '0;
   logic [7:0] b_in = '0;

   logic [15:0] p_wide;
   logic [1:0]  p1;
   logic [3:0]  p2;
   logic [5:0]  p3;
   logic [7:0]  p4;
   logic [9:0]  p5;

   bw_mult #(.WA(8), .WB(6)) uut (.mcand_i(a_in), .mplier_i(b_in[5:0]), .prod_o(p_wide));
   bw_mult #(.WA(1), .WB(1)) u_w1 (.mcand_i(a_in[0]),   .mplier_i(b_in[0]),   .prod_o(p1));
   bw_mult #(.WA(2), .WB(2)) u_w2 (.mcand_i(a_in[1:0]), .mplier_i(b_in[1:0]), .prod_o(p2));
   bw_mult #(.WA(3), .WB(3)) u_w3 (.mcand_i(a_in[2:0]), .mplier_i(b_in[2:0]), .prod_o(p3));
   bw_mult #(.WA(4), .WB(4)) u_w4 (.mcand_i(a_in[3:0]), .mplier_i(b_in[3:0]), .prod_o(p4));
   bw_mult #(.WA(5), .WB(5)) u_w5 (.mcand_i(a_in[4:0]), .mplier_i(b_in[4:0]), .prod_o(p5));

   int total = 0;
   int bad   = 0;
   int cycles = 0;

   function automatic logic [15:0] square_out(input int w);
      case (w)
         1:       return 16'(p1);
         2:       return 16'(p2);
         3:       return 16'(p3);
         4:       return 16'(p4);
         5:       return 16'(p5);
         default: return p_wide;
      endcase
   endfunction

   function automatic int to_signed(input int v, input int w);
      return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
   endfunction

   // expected product, wa/wb operand widths, n = larger width
   function automatic logic [15:0] exp_prod(input int wa, input int wb, input int a, input int b);
      int n;
      int p;
      n = (wa > wb) ? wa : wb;
      p = to_signed(a, wa) * to_signed(b, wb);
      return 16'(p & ((1 << (2 * n)) - 1));
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input int a, input int b);
      @(posedge clk);
      a_in = 8'(a);
      b_in = 8'(b);
      @(negedge clk);
   endtask

   // R6 with all-zero inputs held during reset
   task automatic t_reset();
      rst = 1'b1;
      apply(0, 0);
      for (int w = 1; w <= 5; w++) check("R6 reset zero", square_out(w), 16'h0);
      check("R6 reset zero wide", p_wide, 16'h0);
      rst = 1'b0;
   endtask

   // R1, R3, R4, R6, R7, R8: exhaustive square widths
   task automatic t_sweep(input int w);
      for (int a = 0; a < (1 << w); a++) begin
         for (int b = 0; b < (1 << w); b++) begin
            logic [15:0] got;
            logic [15:0] exp;
            apply(a, b);
            got = square_out(w);
            exp = exp_prod(w, w, a, b);
            check("R1 R8 product", got, exp);
            check("R3 bit0", 16'(got[0]), 16'((a & b) & 1));
            if (w == 1) check("R4 upper bit", 16'(got[1]), 16'h0);
            if (a == 0 || b == 0) check("R6 zero", got, 16'h0);
            else check("R7 sign", 16'(got[2*w-1]),
                       16'((to_signed(a, w) < 0) != (to_signed(b, w) < 0)));
         end
      end
   endtask

   // R1, R2: exhaustive unequal widths
   task automatic t_wide();
      for (int a = 0; a < 256; a++) begin
         for (int b = 0; b < 64; b++) begin
            apply(a, b);
            check("R1 R2 wide product", p_wide, exp_prod(8, 6, a, b));
         end
      end
      apply(1, 6'h20);
      check("R2 extended -32", p_wide, 16'hFFE0);
      apply(8'h80, 6'h20);
      check("R2 -128*-32", p_wide, 16'h1000);
   endtask

   // R5: most negative squared
   task automatic t_corners();
      for (int w = 1; w <= 5; w++) begin
         apply(1 << (w - 1), 1 << (w - 1));
         check("R5 most negative squared", square_out(w), 16'(1 << (2 * w - 2)));
      end
      apply(4'h8, 4'h8);
      check("R5 n4 -8*-8", 16'(p4), 16'h0040);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      for (int w = 1; w <= 5; w++) t_sweep(w);
      t_wide();
      t_corners();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule